// File: doc/BRIEF.md
# Interval Timer with Oscillator Stabilization Hold-off

This block is an 8-bit binary up-counter fed by a prescaler. In normal running it gives a periodic interrupt each time the counter wraps from 255 back to 0, so software can use it as a coarse watch tick. The same counter also measures the oscillator settling time. After a reset, or after a wake from stop mode, the stabilization-done flag stays low until the counter wraps for the first time. The core uses that flag to stay in its waiting state.

The prescaler divides the system clock by a power of two between 16 and 2048. The ratio is held in a 3-bit register that comes out of reset selecting 512 and is loaded from the select field on a load strobe. A separate source bit changes the prescaler so that it counts single-cycle ring-oscillator ticks instead, one count step per 1024 ticks, and the ratio register is then ignored. A clear input zeroes the counter and the prescaler.

Top module: `itmr_top`

## Requirements
- R1: While rst is high (synchronous, active high), on each clock edge count becomes 0, stab_done and irq become 0, and the ratio register returns to encoding 3'b101 (divide by 512).
- R2: With alt_src low, ratio encodings 3'b000 through 3'b111 give divide-by 16, 32, 64, 128, 256, 512, 1024 and 2048 system clocks. An encoding on div_sel is taken into the ratio register on a clock edge where sel_load is high, and it governs from the next edge onward. After a clear, count reaches 1 on exactly the ratio-th following edge.
- R3: With no load after reset, count first becomes 1 on the 512th edge after rst falls.
- R4: With alt_src high, the prescaler advances only on edges where ring_tick is high. Count steps once per 1024 such edges whatever the ratio register holds. With alt_src low, ring_tick has no effect.
- R5: count is 8-bit binary: it changes by at most +1 per edge outside clear and wake, and it wraps from 255 to 0.
- R6: stab_done rises on the edge of the first 255-to-0 wrap after reset or wake. It then stays high until the next reset or wake.
- R7: irq is high for exactly one cycle, starting on the edge where count wraps to 0, and only then.
- R8: An edge with stop_wake high sets count, prescaler, stab_done and irq to 0.
- R9: An edge with clr high sets count and prescaler to 0 and leaves stab_done unchanged.
- R10: Loading a new ratio does not clear the prescaler. If the prescaler has already reached the new ratio minus one, the count steps on the next advancing edge.
- R11: Priority is rst over stop_wake over clr. With stop_wake and clr high together, stab_done is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | Ratio encoding presented for loading |
| sel_load | input | 1 | Takes div_sel into the ratio register |
| alt_src | input | 1 | 1 = count ring-oscillator ticks at divide-by-1024 |
| ring_tick | input | 1 | Synchronized single-cycle ring-oscillator tick |
| stop_wake | input | 1 | Wake-from-stop event, restarts the hold-off |
| clr | input | 1 | Clears counter and prescaler |
| stab_done | output | 1 | Oscillator stabilization delay has elapsed |
| irq | output | 1 | One-cycle interval interrupt on each wrap |
| count | output | 8 | Current counter value |

## Verification
The bench aims at the exact edge on which the count first steps after reset, for every ratio. A design with a wrong default or an off-by-one prescaler limit steps one or more cycles early or late. It switches the ratio down while the prescaler is far past the new limit. A design that stalls there, or clears the prescaler on a load, loses or delays a step. It drives clear and wake together and runs ring-oscillator mode with no ticks, so a design that gives clear priority, or that still counts system clocks in that mode, leaves stab_done high or moves the count.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int CNT_W      = 8;
    localparam int SEL_W      = 3;
    localparam int BASE_SHIFT = 4;
    localparam int ALT_SHIFT  = 10;
    localparam int PRE_W      = BASE_SHIFT + (1 << SEL_W) - 1;
    localparam logic [SEL_W-1:0] SEL_RST = 3'd5;

    typedef enum logic {
        SRC_SYS  = 1'b0,
        SRC_RING = 1'b1
    } src_e;

    typedef struct packed {
        logic restart;  // wake event: also drops the done flag
        logic zero;     // clear event: counter and prescaler only
    } ctl_t;

    // Terminal prescaler value for a source and ratio encoding.
    function automatic logic [PRE_W-1:0] top_of(src_e s, logic [SEL_W-1:0] sel);
        int unsigned sh;
        sh = (s == SRC_RING) ? ALT_SHIFT : BASE_SHIFT + int'(sel);
        return PRE_W'((32'd1 << sh) - 32'd1);
    endfunction
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
    import itmr_pkg::*;
#(
    parameter int P_W = PRE_W,
    parameter int S_W = SEL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  src_e           src,
    input  logic [S_W-1:0] sel,
    input  logic           ring_tick,
    input  logic           flush,
    output logic           tick
);
    logic [P_W-1:0] pre;
    logic [P_W-1:0] limit;
    logic           step;
    logic           at_top;

    always_comb begin
        limit  = P_W'(top_of(src, SEL_W'(sel)));
        step   = (src == SRC_RING) ? ring_tick : 1'b1;
        at_top = (pre >= limit);
        tick   = step && at_top && !flush;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pre <= '0;
        end else if (step) begin
            pre <= at_top ? '0 : pre + 1'b1;
        end
    end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int C_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           flush,
    input  logic           tick,
    output logic [C_W-1:0] value,
    output logic           wrap
);
    assign wrap = tick && (value == {C_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            value <= '0;
        end else if (tick) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/itmr_status.sv
module itmr_status
    import itmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic wrap,
    output logic done,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst || ctl.restart) begin
            done <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= wrap;
            if (wrap) begin
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/itmr_top.sv
module itmr_top
    import itmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] div_sel,
    input  logic          sel_load,
    input  logic          alt_src,
    input  logic          ring_tick,
    input  logic          stop_wake,
    input  logic          clr,
    output logic          stab_done,
    output logic          irq,
    output logic [CW-1:0] count
);
    localparam int PW = BASE_SHIFT + (1 << SW) - 1;

    logic [SW-1:0] ratio_q;
    ctl_t          ctl;
    src_e          src;
    logic          flush;
    logic          tick;
    logic          wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= SW'(SEL_RST);
        end else if (sel_load) begin
            ratio_q <= div_sel;
        end
    end

    always_comb begin
        ctl.restart = stop_wake;
        ctl.zero    = clr;
        flush       = ctl.restart | ctl.zero;
        src         = alt_src ? SRC_RING : SRC_SYS;
    end

    itmr_prescaler #(.P_W(PW), .S_W(SW)) u_pre (
        .clk(clk), .rst(rst), .src(src), .sel(ratio_q),
        .ring_tick(ring_tick), .flush(flush), .tick(tick)
    );

    itmr_counter #(.C_W(CW)) u_cnt (
        .clk(clk), .rst(rst), .flush(flush), .tick(tick),
        .value(count), .wrap(wrap)
    );

    itmr_status u_stat (
        .clk(clk), .rst(rst), .ctl(ctl), .wrap(wrap),
        .done(stab_done), .irq(irq)
    );
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          stop_wake,
    input logic          clr,
    input logic          stab_done,
    input logic          irq,
    input logic [CW-1:0] count
);
    a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
    a_r7_irq_at_wrap: assert property (@(posedge clk) disable iff (rst)
        irq |-> (count == '0));
    a_r6_done_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(stab_done) |-> irq);
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (stab_done && !stop_wake) |=> stab_done);
    a_r8_wake_clears: assert property (@(posedge clk) disable iff (rst)
        stop_wake |=> (count == '0 && !stab_done && !irq));
    a_r9_clr_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));
    a_r5_unit_step: assert property (@(posedge clk) disable iff (rst)
        (!stop_wake && !clr) |=>
            (count == $past(count) || count == CW'($past(count) + 1'b1)));
endmodule

bind itmr_top itmr_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .stop_wake(stop_wake), .clr(clr),
    .stab_done(stab_done), .irq(irq), .count(count)
);

// File: tb/itmr_top_bench.sv
`timescale 1ns/1ps
module itmr_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] div_sel = 3'd0;
    logic       sel_load = 1'b0;
    logic       alt_src = 1'b0;
    logic       ring_tick = 1'b0;
    logic       stop_wake = 1'b0;
    logic       clr = 1'b0;
    logic       stab_done;
    logic       irq;
    logic [7:0] count;

    int n_chk = 0;
    int n_bad = 0;

    // expected state, derived from the requirements
    int         m_pre = 0;
    int         m_cnt = 0;
    logic       m_done = 1'b0;
    logic       m_irq = 1'b0;
    logic [2:0] m_sel = 3'd5;

    always #10 clk = ~clk;

    itmr_top u_itmr_top (
        .clk(clk), .rst(rst), .div_sel(div_sel), .sel_load(sel_load),
        .alt_src(alt_src), .ring_tick(ring_tick), .stop_wake(stop_wake),
        .clr(clr), .stab_done(stab_done), .irq(irq), .count(count)
    );

    function automatic int ratio_of(logic alt, logic [2:0] s);
        return alt ? 1024 : (16 << s);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_done = 0; m_irq = 0; m_sel = 3'd5;
        end else begin
            int lim;
            logic stp;
            lim = ratio_of(alt_src, m_sel) - 1;
            stp = alt_src ? ring_tick : 1'b1;
            m_irq = 1'b0;
            if (stop_wake || clr) begin
                m_pre = 0; m_cnt = 0;
                if (stop_wake) m_done = 1'b0;
            end else if (stp) begin
                if (m_pre >= lim) begin
                    m_pre = 0;
                    if (m_cnt == 255) begin
                        m_cnt = 0; m_irq = 1'b1; m_done = 1'b1;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end else begin
                    m_pre = m_pre + 1;
                end
            end
            if (sel_load) m_sel = div_sel;
        end
    end

    task automatic check(logic ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        check(count == 8'(m_cnt), "R5 count", int'(count), m_cnt);
        check(stab_done == m_done, "R6 stab_done", int'(stab_done), int'(m_done));
        check(irq == m_irq, "R7 irq", int'(irq), int'(m_irq));
    endtask

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            cmp_model();
        end
    endtask

    task automatic quiet();
        sel_load = 0; clr = 0; stop_wake = 0; ring_tick = 0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        cyc(3);
        check(count == 0 && !stab_done && !irq, "R1 reset", int'(count), 0);
        // R3: default divide by 512
        rst = 0;
        cyc(511);
        check(count == 0, "R3 before 512", int'(count), 0);
        cyc(1);
        check(count == 1, "R3 at 512", int'(count), 1);
        // R2: each encoding
        for (int s = 0; s < 8; s++) begin
            div_sel = 3'(s); sel_load = 1; clr = 1;
            cyc(1);
            quiet();
            cyc((16 << s) - 1);
            check(count == 0, "R2 before ratio", int'(count), 0);
            cyc(1);
            check(count == 1, "R2 at ratio", int'(count), 1);
        end
        // R5 R6 R7: first wrap with divide by 16
        div_sel = 3'd0; sel_load = 1; clr = 1;
        cyc(1);
        quiet();
        cyc(4095);
        check(!stab_done && count == 255, "R6 before wrap", int'(count), 255);
        cyc(1);
        check(stab_done && irq && count == 0, "R7 wrap pulse", int'(irq), 1);
        cyc(1);
        check(!irq && stab_done, "R7 one cycle", int'(irq), 0);
        // R9: clear keeps done
        cyc(40);
        clr = 1; cyc(1); quiet();
        check(count == 0 && stab_done, "R9 clear", int'(stab_done), 1);
        // R11: wake and clear together drop done
        cyc(30);
        clr = 1; stop_wake = 1; cyc(1); quiet();
        check(count == 0 && !stab_done, "R11 priority", int'(stab_done), 0);
        // R10: ratio drop below current prescaler
        div_sel = 3'd7; sel_load = 1; clr = 1; cyc(1); quiet();
        cyc(100);
        div_sel = 3'd0; sel_load = 1; cyc(1); quiet();
        check(count == 0, "R10 load edge", int'(count), 0);
        cyc(1);
        check(count == 1, "R10 immediate step", int'(count), 1);
        // R4: ring source ignores ratio and system clock
        alt_src = 1; clr = 1; cyc(1); quiet();
        cyc(100);
        check(count == 0, "R4 no ticks", int'(count), 0);
        ring_tick = 1; cyc(1023);
        check(count == 0, "R4 before 1024", int'(count), 0);
        cyc(1); ring_tick = 0;
        check(count == 1, "R4 at 1024", int'(count), 1);
        alt_src = 0;
        // random mix
        for (int i = 0; i < 20000; i++) begin
            sel_load  = ($urandom % 300) == 0;
            div_sel   = ($urandom % 8 == 0) ? 3'($urandom) : 3'($urandom % 2);
            if ($urandom % 800 == 0) alt_src = ~alt_src;
            ring_tick = ($urandom % 2) == 1;
            clr       = ($urandom % 3000) == 0;
            stop_wake = ($urandom % 5000) == 0;
            cyc(1);
        end
        quiet(); alt_src = 0;
        // R8: wake after hold-off completed
        div_sel = 3'd0; sel_load = 1; clr = 1; cyc(1); quiet();
        cyc(4100);
        check(stab_done == 1, "R8 done before wake", int'(stab_done), 1);
        stop_wake = 1; cyc(1); quiet();
        check(count == 0 && !stab_done && !irq, "R8 wake", int'(stab_done), 0);
        cyc(4095);
        check(!stab_done, "R8 hold-off", int'(stab_done), 0);
        cyc(1);
        check(stab_done, "R6 release after wake", int'(stab_done), 1);
        // R1 again: reset restores divide by 512
        rst = 1; cyc(2); rst = 0;
        cyc(512);
        check(count == 1, "R1 ratio default", int'(count), 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule